// File: doc/BRIEF.md
# Power Mode and Slow-Clock Controller

This block turns a free-running oscillator reference into a one-cycle clock-enable pulse for the processor core and its peripherals. It also sequences the device through its power-saving states. The normal rate is one pulse every two reference cycles. A slow-mode bit together with a two-bit rate code stretches the period to 4, 8, 16 or 32 reference cycles. A new rate setting waits in a holding register and is applied only at the end of the current divider period, so no enable pulse is ever shortened or merged.

Sleep requests move the block out of its active state. A wait request stops the core but leaves the peripherals running. From slow mode, the same request leads to a slow-wait state that keeps the slow rate. A halt request stops every enable. An active-halt request stops the core and the peripherals but keeps a wake-up timer enable running. A wake-up event brings the block back to the active rate it had before it slept. A one-hot vector reports the current mode.

Top module: `pmu_rate_ctrl`

## Requirements
- R1: After reset the mode is RUN (mode_oh = 6'b000001), slow mode is off, and rate_tick pulses once every 2 reference cycles, first in the second cycle after reset is released.
- R2: With slow mode active, the period of rate_tick is 4, 8, 16 or 32 cycles for rate codes 00, 01, 10 and 11.
- R3: A configuration write changes the period only after the rate_tick that ends the current period. rate_tick is never high in two consecutive cycles.
- R4: In RUN and SLOW, cpu_ce and per_ce both pulse exactly with rate_tick, and wkt_ce stays low.
- R5: A wait request from RUN enters WAIT (bit 2); from SLOW it enters SLOW-WAIT (bit 3). In both states per_ce follows rate_tick and cpu_ce stays low.
- R6: In HALT (bit 5), rate_tick, cpu_ce, per_ce and wkt_ce all stay low.
- R7: In ACTIVE-HALT (bit 4), cpu_ce and per_ce stay low while wkt_ce pulses with rate_tick.
- R8: A wake-up event returns WAIT to RUN and SLOW-WAIT to SLOW. From HALT or ACTIVE-HALT it returns to the mode active before entry. In every case the divide ratio is unchanged.
- R9: Configuration writes made in WAIT, SLOW-WAIT, ACTIVE-HALT or HALT are discarded.
- R10: In RUN or SLOW, simultaneous requests resolve as halt over active-halt over wait. Sleep requests made while already asleep are ignored. mode_oh always has exactly one bit set: bit 0 RUN, 1 SLOW, 2 WAIT, 3 SLOW-WAIT, 4 ACTIVE-HALT, 5 HALT.
- R11: A wake-up event in RUN or SLOW has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the rate setting |
| cfg_slow | input | 1 | Slow-mode enable written with cfg_wr |
| cfg_rate | input | SEL_W | Slow rate code written with cfg_wr |
| wait_req | input | 1 | Request to enter WAIT or SLOW-WAIT |
| halt_req | input | 1 | Request to enter HALT |
| ahalt_req | input | 1 | Request to enter ACTIVE-HALT |
| wake | input | 1 | Wake-up event |
| rate_tick | output | 1 | Divider terminal-count pulse |
| cpu_ce | output | 1 | Core clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| wkt_ce | output | 1 | Wake-up timer enable in ACTIVE-HALT |
| mode_oh | output | 6 | One-hot current mode |

## Verification
The bench builds the block with its default two-bit rate code and the up-counting divider. This covers the full ladder from /2 to /32 in a few hundred cycles. The slowest period, 32 cycles, is short enough that rate changes, sleeps and wake-ups can land at every phase of a period during the randomized phase. This includes a pending write that is applied while the block is asleep.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   typedef enum logic [1:0] {
      PS_ACTIVE = 2'd0,
      PS_WAIT   = 2'd1,
      PS_AHALT  = 2'd2,
      PS_HALT   = 2'd3
   } pstate_e;

   localparam int MODE_N   = 6;
   localparam int MD_RUN   = 0;
   localparam int MD_SLOW  = 1;
   localparam int MD_WAIT  = 2;
   localparam int MD_SWAIT = 3;
   localparam int MD_AHALT = 4;
   localparam int MD_HALT  = 5;

   function automatic logic [MODE_N-1:0] mode_vec(input pstate_e st, input logic slow);
      logic [MODE_N-1:0] v;
      v = '0;
      case (st)
         PS_ACTIVE: v[slow ? MD_SLOW : MD_RUN] = 1'b1;
         PS_WAIT:   v[slow ? MD_SWAIT : MD_WAIT] = 1'b1;
         PS_AHALT:  v[MD_AHALT] = 1'b1;
         default:   v[MD_HALT] = 1'b1;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pmu_rate_reg.sv
module pmu_rate_reg #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_slow,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             load,
   output logic             pend_slow,
   output logic [SEL_W-1:0] pend_sel,
   output logic             act_slow,
   output logic [SEL_W-1:0] act_sel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_slow <= 1'b0;
         pend_sel  <= '0;
      end else if (wr_en) begin
         pend_slow <= wr_slow;
         pend_sel  <= wr_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_slow <= 1'b0;
         act_sel  <= '0;
      end else if (load) begin
         act_slow <= pend_slow;
         act_sel  <= pend_sel;
      end
   end

endmodule

// File: rtl/pmu_divider.sv
module pmu_divider #(
   parameter int SEL_W      = 2,
   parameter int BASE_LOG2  = 1,
   parameter int SLOW_LOG2  = 2,
   parameter int COUNT_DOWN = 0,
   parameter int CNT_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cur_slow,
   input  logic [SEL_W-1:0] cur_sel,
   input  logic             nxt_slow,
   input  logic [SEL_W-1:0] nxt_sel,
   output logic             tick
);

   function automatic logic [CNT_W-1:0] last_of(input logic slow, input logic [SEL_W-1:0] sel);
      int lg;
      lg = slow ? (SLOW_LOG2 + int'(sel)) : BASE_LOG2;
      return CNT_W'((1 << lg) - 1);
   endfunction

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cur_last;
   logic [CNT_W-1:0] nxt_last;

   assign cur_last = last_of(cur_slow, cur_sel);
   assign nxt_last = last_of(nxt_slow, nxt_sel);

   generate
      if (COUNT_DOWN != 0) begin : g_down
         assign tick = run && (cnt == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= CNT_W'((1 << BASE_LOG2) - 1);
            else if (!run)   cnt <= cur_last;
            else if (tick)   cnt <= nxt_last;
            else             cnt <= cnt - 1'b1;
         end
      end else begin : g_up
         logic unused_nxt;
         assign unused_nxt = ^nxt_last;
         assign tick = run && (cnt == cur_last);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (!run || tick)   cnt <= '0;
            else                     cnt <= cnt + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
   import pmu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wait_req,
   input  logic    halt_req,
   input  logic    ahalt_req,
   input  logic    wake,
   output pstate_e state
);

   pstate_e state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         PS_ACTIVE: begin
            if (halt_req)       state_nx = PS_HALT;
            else if (ahalt_req) state_nx = PS_AHALT;
            else if (wait_req)  state_nx = PS_WAIT;
         end
         PS_WAIT, PS_AHALT, PS_HALT: begin
            if (wake) state_nx = PS_ACTIVE;
         end
         default: state_nx = PS_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_ACTIVE;
      else        state <= state_nx;
   end

endmodule

// File: rtl/pmu_rate_ctrl.sv
module pmu_rate_ctrl
   import pmu_pkg::*;
#(
   parameter int SEL_W      = 2,
   parameter int BASE_LOG2  = 1,
   parameter int SLOW_LOG2  = 2,
   parameter int COUNT_DOWN = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_slow,
   input  logic [SEL_W-1:0] cfg_rate,
   input  logic             wait_req,
   input  logic             halt_req,
   input  logic             ahalt_req,
   input  logic             wake,
   output logic             rate_tick,
   output logic             cpu_ce,
   output logic             per_ce,
   output logic             wkt_ce,
   output logic [5:0]       mode_oh
);

   localparam int MAX_LOG2 = SLOW_LOG2 + (1 << SEL_W) - 1;
   localparam int CNT_W    = MAX_LOG2;

   if (BASE_LOG2 < 1 || BASE_LOG2 >= SLOW_LOG2) begin : g_bad_base
      $error("pmu_rate_ctrl: BASE_LOG2 must be at least 1 and below SLOW_LOG2");
   end
   if (SEL_W < 1 || MAX_LOG2 > 24) begin : g_bad_sel
      $error("pmu_rate_ctrl: SEL_W gives a divider wider than 24 bits");
   end
   if (MODE_N != 6) begin : g_bad_mode
      $error("pmu_rate_ctrl: mode vector width mismatch");
   end

   pstate_e          state;
   logic             pend_slow, act_slow;
   logic [SEL_W-1:0] pend_sel, act_sel;
   logic             awake;
   logic             div_run;

   assign awake   = (state == PS_ACTIVE);
   assign div_run = (state != PS_HALT);

   pmu_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_req  (wait_req),
      .halt_req  (halt_req),
      .ahalt_req (ahalt_req),
      .wake      (wake),
      .state     (state)
   );

   pmu_rate_reg #(.SEL_W(SEL_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr && awake),
      .wr_slow   (cfg_slow),
      .wr_sel    (cfg_rate),
      .load      (rate_tick),
      .pend_slow (pend_slow),
      .pend_sel  (pend_sel),
      .act_slow  (act_slow),
      .act_sel   (act_sel)
   );

   pmu_divider #(
      .SEL_W      (SEL_W),
      .BASE_LOG2  (BASE_LOG2),
      .SLOW_LOG2  (SLOW_LOG2),
      .COUNT_DOWN (COUNT_DOWN),
      .CNT_W      (CNT_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (div_run),
      .cur_slow (act_slow),
      .cur_sel  (act_sel),
      .nxt_slow (pend_slow),
      .nxt_sel  (pend_sel),
      .tick     (rate_tick)
   );

   assign cpu_ce  = rate_tick && awake;
   assign per_ce  = rate_tick && (awake || state == PS_WAIT);
   assign wkt_ce  = rate_tick && (state == PS_AHALT);
   assign mode_oh = mode_vec(state, act_slow);

endmodule

module pmu_rate_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wait_req,
   input logic       halt_req,
   input logic       ahalt_req,
   input logic       wake,
   input logic       rate_tick,
   input logic       cpu_ce,
   input logic       per_ce,
   input logic       wkt_ce,
   input logic [5:0] mode_oh
);

   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_oh) == 1);

   p_no_back2back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rate_tick |=> !rate_tick);

   p_active_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[0] || mode_oh[1]) |-> (cpu_ce == rate_tick && per_ce == rate_tick && !wkt_ce));

   p_wait_cpu_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[2] || mode_oh[3]) |-> (!cpu_ce && per_ce == rate_tick));

   p_slow_wait_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[1] && wait_req && !halt_req && !ahalt_req && !rate_tick) |=> mode_oh[3]);

   p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_oh[5] |-> !(rate_tick || cpu_ce || per_ce || wkt_ce));

   p_ahalt_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_oh[4] |-> (!cpu_ce && !per_ce && wkt_ce == rate_tick));

   p_wake_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[2] && wake && !rate_tick) |=> mode_oh[0]);

   p_halt_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_oh[0] || mode_oh[1]) && halt_req) |=> mode_oh[5]);

   p_wake_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_oh[0] && wake && !halt_req && !ahalt_req && !wait_req && !rate_tick) |=> mode_oh[0]);

endmodule

bind pmu_rate_ctrl pmu_rate_ctrl_chk u_chk (.*);

// File: tb/pmu_rate_ctrl_tb.sv
`timescale 1ns/1ps
module pmu_rate_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic       cfg_slow = 1'b0;
   logic [1:0] cfg_rate = 2'd0;
   logic       wait_req = 1'b0;
   logic       halt_req = 1'b0;
   logic       ahalt_req = 1'b0;
   logic       wake = 1'b0;
   logic       rate_tick, cpu_ce, per_ce, wkt_ce;
   logic [5:0] mode_oh;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;

   pmu_rate_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_slow(cfg_slow), .cfg_rate(cfg_rate),
      .wait_req(wait_req), .halt_req(halt_req), .ahalt_req(ahalt_req), .wake(wake),
      .rate_tick(rate_tick), .cpu_ce(cpu_ce), .per_ce(per_ce), .wkt_ce(wkt_ce), .mode_oh(mode_oh)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // Behavioural reference: st 0 awake, 1 wait, 2 active-halt, 3 halt
   int m_cnt, m_st, m_asel, m_psel;
   bit m_aslow, m_pslow;

   function automatic int m_period();
      return m_aslow ? (4 << m_asel) : 2;
   endfunction
   function automatic bit m_tick();
      return (m_st != 3) && (m_cnt == m_period() - 1);
   endfunction
   function automatic int m_mode();
      case (m_st)
         0: return m_aslow ? 2 : 1;
         1: return m_aslow ? 8 : 4;
         2: return 16;
         default: return 32;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_st = 0; m_asel = 0; m_psel = 0; m_aslow = 0; m_pslow = 0;
      end else begin
         bit t;
         bit os;
         int oq;
         t = m_tick();
         os = m_pslow; oq = m_psel;
         if (m_st == 3 || t) m_cnt = 0; else m_cnt = m_cnt + 1;
         if (cfg_wr && m_st == 0) begin m_pslow = cfg_slow; m_psel = int'(cfg_rate); end
         if (t) begin m_aslow = os; m_asel = oq; end
         case (m_st)
            0: m_st = halt_req ? 3 : ahalt_req ? 2 : wait_req ? 1 : 0;
            default: if (wake) m_st = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit t;
         t = m_tick();
         chk("R3 rate_tick", int'(rate_tick), int'(t));
         chk("R10 mode_oh", int'(mode_oh), m_mode());
         chk("R4 cpu_ce", int'(cpu_ce), int'(t && m_st == 0));
         chk("R5 per_ce", int'(per_ce), int'(t && m_st <= 1));
         chk("R7 wkt_ce", int'(wkt_ce), int'(t && m_st == 2));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cfg(input bit s, input int r);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_slow = s; cfg_rate = 2'(r);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: wait_req = 1'b1;
         1: halt_req = 1'b1;
         2: ahalt_req = 1'b1;
         default: wake = 1'b1;
      endcase
      @(negedge clk);
      wait_req = 1'b0; halt_req = 1'b0; ahalt_req = 1'b0; wake = 1'b0;
   endtask

   task automatic measure(output int per);
      int g;
      g = 0;
      while (!rate_tick && g < 100) begin @(negedge clk); g++; end
      per = 0;
      do begin @(negedge clk); per++; end while (!rate_tick && per < 100);
   endtask

   initial begin
      int p, cnt_w;
      cyc(3);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state and base rate
      chk("R1 mode after reset", int'(mode_oh), 1);
      measure(p); chk("R1 base period", p, 2);

      // R2: each slow code
      for (int k = 0; k < 4; k++) begin
         write_cfg(1'b1, k);
         measure(p); measure(p);
         chk("R2 slow period", p, 4 << k);
      end
      chk("R2 slow mode bit", int'(mode_oh), 2);

      // R11: wake while awake
      pulse(3); chk("R11 wake ignored", int'(mode_oh), 2);

      // R5: wait from slow enters slow-wait
      pulse(0); chk("R5 slow-wait entry", int'(mode_oh), 8);
      // R9: write during slow-wait discarded; R10: sleep requests ignored
      write_cfg(1'b0, 0);
      pulse(1); chk("R10 halt ignored in wait", int'(mode_oh), 8);
      cyc(40);
      pulse(3); chk("R8 slow-wait to slow", int'(mode_oh), 2);
      measure(p); measure(p); chk("R9 rate kept after write in wait", p, 32);

      // R6: halt keeps everything quiet
      pulse(1); chk("R6 halt entered", int'(mode_oh), 32);
      cnt_w = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); cnt_w += int'(rate_tick); end
      chk("R6 no ticks in halt", cnt_w, 0);
      pulse(3); chk("R8 halt returns to slow", int'(mode_oh), 2);
      measure(p); chk("R8 ratio kept after halt", p, 32);

      // R7: active-halt timer
      write_cfg(1'b1, 0); measure(p); measure(p);
      pulse(2); chk("R7 active-halt entered", int'(mode_oh), 16);
      cnt_w = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); cnt_w += int'(wkt_ce); end
      chk("R7 timer pulses", cnt_w, 5);
      pulse(3); chk("R8 active-halt returns to slow", int'(mode_oh), 2);

      // back to run, plain wait
      write_cfg(1'b0, 0); measure(p); measure(p);
      chk("R1 base period restored", p, 2);
      pulse(0); chk("R5 wait entry", int'(mode_oh), 4);
      pulse(3); chk("R8 wait to run", int'(mode_oh), 1);

      // R10: priority with simultaneous requests
      @(negedge clk); wait_req = 1'b1; ahalt_req = 1'b1;
      @(negedge clk); wait_req = 1'b0; ahalt_req = 1'b0;
      chk("R10 active-halt over wait", int'(mode_oh), 16);
      pulse(3);
      @(negedge clk); wait_req = 1'b1; halt_req = 1'b1; ahalt_req = 1'b1;
      @(negedge clk); wait_req = 1'b0; halt_req = 1'b0; ahalt_req = 1'b0;
      chk("R10 halt wins", int'(mode_oh), 32);
      pulse(3);

      // randomized mix compared against the reference every cycle
      for (int i = 0; i < 6000; i++) begin
         int r;
         @(negedge clk);
         r = int'($urandom % 1000);
         cfg_wr    = (r % 13) == 0;
         cfg_slow  = r[4];
         cfg_rate  = r[6:5];
         wait_req  = (r % 37) == 1;
         halt_req  = (r % 97) == 2;
         ahalt_req = (r % 89) == 3;
         wake      = (r % 19) == 4;
      end
      @(negedge clk);
      cfg_wr = 1'b0; wait_req = 1'b0; halt_req = 1'b0; ahalt_req = 1'b0; wake = 1'b0;
      cyc(4);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule